// File: doc/BRIEF.md
# Atomic Memory Unit with Full/Empty Word Tags

This block is a memory-side execution unit in front of a small word-addressed store. Each 64-bit word holds one extra synchronization tag (1 = full, 0 = empty). A requester sends one request that names an atomic operation. The unit reads the word, computes the new value, checks the tag condition and writes back, all in a single serialized pass. The requester never acquires a lock, updates the data and releases the lock as separate transactions.

Two families of operation share the one read-modify-write path. Plain atomics change the data and leave the tag as it is. Tag-conditioned reads and writes first test the tag. They either commit and set a new tag state, or they are refused with a RETRY status so that the requesting thread can pend and try again. Every response returns the word's value and tag as they were before the operation, together with a status code and the requester's thread id.

Requests arrive on a valid/ready channel. Responses leave on a valid/ready channel one cycle after acceptance. A new request is accepted only when the response register is free or is being drained in the same cycle.

Top module: `amo_fe_unit`

## Requirements
- R1: After reset every word reads as zero with its tag empty (0), rsp_valid_o is low and req_ready_o is high.
- R2: A request accepted on a clock edge produces its response on the next edge. The response carries the word's data and tag from before the operation, plus the request's thread id.
- R3: Add (opcode 0) and subtract (1) use the operand. Increment (5) and decrement (6) ignore the operand and use 1. All four wrap modulo 2^64.
- R4: Minimum (2) and maximum (3) compare the stored word and the operand as signed 64-bit two's-complement values, and store the smaller or larger one.
- R5: Exchange (4) stores the operand. AND (8), OR (9) and XOR (10) store the bitwise result of the word and the operand.
- R6: Compare-and-swap (7) stores the operand only when the stored word equals the compare value, with status OK (0). Otherwise the word is unchanged and the status is CAS_FAIL (2).
- R7: Tag opcodes are decoded as (required tag -> new tag), with "any" meaning no test: 11 write (empty->full), 12 write (full->full), 13 write (any->full), 14 write (any->empty), 15 read (full->empty), 16 read (empty->full), 17 read (full->full), 18 read (any->unchanged), 19 increment (full->full). Writes store the operand.
- R8: When a tag operation's required tag does not match, neither the data nor the tag changes, and the status is RETRY (1).
- R9: Plain atomics (opcodes 0 to 10) do not test the tag and leave it unchanged.
- R10: Requests to the same address on consecutive cycles each see the result of the one before.
- R11: Opcodes 20 to 31 change nothing and return status BAD_OP (3).
- R12: While rsp_valid_o is high and rsp_ready_i is low, the response holds stable and no new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_op_i | input | 5 | Operation code |
| req_addr_i | input | AW | Word address (AW = clog2(DEPTH)) |
| req_opnd_i | input | 64 | Operand or write data |
| req_cmp_i | input | 64 | Compare value for compare-and-swap |
| req_tid_i | input | TID_W | Requester thread id |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response can be taken |
| rsp_data_o | output | 64 | Word data before the operation |
| rsp_tag_o | output | 1 | Word tag before the operation |
| rsp_status_o | output | 2 | 0 OK, 1 RETRY, 2 CAS_FAIL, 3 BAD_OP |
| rsp_tid_o | output | TID_W | Echoed thread id |

## Verification
The assertions watch the channel on every cycle. They cover one-cycle response latency, the echoed thread id, the stable hold under backpressure, and the agreement between compare-and-swap status and the returned value. They also cover the tag-versus-RETRY relation for full-to-empty reads, the rejection of unknown opcodes, and tag preservation by plain atomics. Only the directed scenarios show that the data actually stored is right. That covers wrap-around arithmetic, signed ordering in min/max, the full sequence of tag states across many operations, the absence of side effects after a refused request, and dependent back-to-back updates to one address.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned OP_W   = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD     = 5'd0,
    OP_SUB     = 5'd1,
    OP_MIN     = 5'd2,
    OP_MAX     = 5'd3,
    OP_XCHG    = 5'd4,
    OP_INC     = 5'd5,
    OP_DEC     = 5'd6,
    OP_CAS     = 5'd7,
    OP_AND     = 5'd8,
    OP_OR      = 5'd9,
    OP_XOR     = 5'd10,
    OP_WR_E2F  = 5'd11,
    OP_WR_F2F  = 5'd12,
    OP_WR_A2F  = 5'd13,
    OP_WR_A2E  = 5'd14,
    OP_RD_F2E  = 5'd15,
    OP_RD_E2F  = 5'd16,
    OP_RD_F2F  = 5'd17,
    OP_RD_ANY  = 5'd18,
    OP_INC_F2F = 5'd19
  } amo_op_e;

  localparam logic [OP_W-1:0] OP_LAST_PLAIN = OP_XOR;
  localparam logic [OP_W-1:0] OP_LAST_LEGAL = OP_INC_F2F;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_RETRY    = 2'd1,
    ST_CAS_FAIL = 2'd2,
    ST_BAD_OP   = 2'd3
  } amo_status_e;
endpackage

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    old_i,
  input  logic [W-1:0]    opnd_i,
  input  logic [W-1:0]    cmp_i,
  output logic [W-1:0]    new_o,
  output logic            cas_hit_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic lt_s;
  assign lt_s      = $signed(old_i) < $signed(opnd_i);
  assign cas_hit_o = (old_i == cmp_i);

  always_comb begin
    unique case (op_i)
      OP_ADD:                    new_o = old_i + opnd_i;
      OP_SUB:                    new_o = old_i - opnd_i;
      OP_MIN:                    new_o = lt_s ? old_i : opnd_i;
      OP_MAX:                    new_o = lt_s ? opnd_i : old_i;
      OP_INC, OP_INC_F2F:        new_o = old_i + ONE;
      OP_DEC:                    new_o = old_i - ONE;
      OP_CAS:                    new_o = cas_hit_o ? opnd_i : old_i;
      OP_AND:                    new_o = old_i & opnd_i;
      OP_OR:                     new_o = old_i | opnd_i;
      OP_XOR:                    new_o = old_i ^ opnd_i;
      OP_XCHG, OP_WR_E2F, OP_WR_F2F,
      OP_WR_A2F, OP_WR_A2E:      new_o = opnd_i;
      default:                   new_o = old_i; // reads and illegal codes
    endcase
  end
endmodule

// File: rtl/fe_tag_rule.sv
module fe_tag_rule
  import amo_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic            tag_i,
  output logic            legal_o,
  output logic            pass_o,
  output logic            tag_o
);
  always_comb begin
    legal_o = 1'b1;
    pass_o  = 1'b1;
    tag_o   = tag_i;
    unique case (op_i)
      OP_WR_E2F:  begin pass_o = ~tag_i; tag_o = 1'b1; end
      OP_WR_F2F:  begin pass_o =  tag_i; tag_o = 1'b1; end
      OP_WR_A2F:  tag_o = 1'b1;
      OP_WR_A2E:  tag_o = 1'b0;
      OP_RD_F2E:  begin pass_o =  tag_i; tag_o = 1'b0; end
      OP_RD_E2F:  begin pass_o = ~tag_i; tag_o = 1'b1; end
      OP_RD_F2F, OP_INC_F2F: pass_o = tag_i;
      OP_RD_ANY:  ;
      default: begin
        // plain atomics keep the tag; codes past the table are refused
        if (op_i > OP_LAST_PLAIN) begin
          legal_o = 1'b0;
          pass_o  = 1'b0;
        end
      end
    endcase
  end
endmodule

// File: rtl/amo_store.sv
module amo_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 64,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o,
  output logic          rd_tag_o,
  input  logic          we_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          wr_tag_i
);
  logic [W:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [W:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 word_q <= '0;
      else if (we_i && wr_addr_i == AW'(g))        word_q <= {wr_tag_i, wr_data_i};
    end
    assign slot[g] = word_q;
  end

  assign {rd_tag_o, rd_data_o} = slot[rd_addr_i];
endmodule

// File: rtl/amo_fe_unit.sv
module amo_fe_unit
  import amo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TID_W = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [OP_W-1:0]   req_op_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [WORD_W-1:0] req_opnd_i,
  input  logic [WORD_W-1:0] req_cmp_i,
  input  logic [TID_W-1:0]  req_tid_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [WORD_W-1:0] rsp_data_o,
  output logic              rsp_tag_o,
  output logic [1:0]        rsp_status_o,
  output logic [TID_W-1:0]  rsp_tid_o
);
  logic [WORD_W-1:0] old_data, new_data;
  logic              old_tag, new_tag;
  logic              legal, pass, cas_hit, fire, commit;
  amo_status_e       status_d;

  logic              rsp_valid_q, rsp_tag_q;
  logic [WORD_W-1:0] rsp_data_q;
  logic [1:0]        rsp_status_q;
  logic [TID_W-1:0]  rsp_tid_q;

  assign req_ready_o = ~rsp_valid_q | rsp_ready_i;
  assign fire        = req_valid_i & req_ready_o;
  assign commit      = fire & legal & pass;

  amo_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (req_addr_i),
    .rd_data_o (old_data),
    .rd_tag_o  (old_tag),
    .we_i      (commit),
    .wr_addr_i (req_addr_i),
    .wr_data_i (new_data),
    .wr_tag_i  (new_tag)
  );

  amo_alu #(.W(WORD_W)) u_alu (
    .op_i      (req_op_i),
    .old_i     (old_data),
    .opnd_i    (req_opnd_i),
    .cmp_i     (req_cmp_i),
    .new_o     (new_data),
    .cas_hit_o (cas_hit)
  );

  fe_tag_rule u_rule (
    .op_i    (req_op_i),
    .tag_i   (old_tag),
    .legal_o (legal),
    .pass_o  (pass),
    .tag_o   (new_tag)
  );

  always_comb begin
    if (!legal)                              status_d = ST_BAD_OP;
    else if (!pass)                          status_d = ST_RETRY;
    else if (req_op_i == OP_CAS && !cas_hit) status_d = ST_CAS_FAIL;
    else                                     status_d = ST_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q  <= 1'b0;
      rsp_data_q   <= '0;
      rsp_tag_q    <= 1'b0;
      rsp_status_q <= ST_OK;
      rsp_tid_q    <= '0;
    end else if (req_ready_o) begin
      rsp_valid_q <= req_valid_i;
      if (req_valid_i) begin
        rsp_data_q   <= old_data;
        rsp_tag_q    <= old_tag;
        rsp_status_q <= status_d;
        rsp_tid_q    <= req_tid_i;
      end
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_data_o   = rsp_data_q;
  assign rsp_tag_o    = rsp_tag_q;
  assign rsp_status_o = rsp_status_q;
  assign rsp_tid_o    = rsp_tid_q;

  // R2
  rsp_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rsp_valid_o);
  // R2
  tid_echo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> rsp_tid_o == $past(req_tid_i));
  // R12
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_data_o)
      && $stable(rsp_tag_o) && $stable(rsp_status_o) && $stable(rsp_tid_o));
  // R6
  cas_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && req_op_i == OP_CAS |=>
      (rsp_status_o == ST_OK) == (rsp_data_o == $past(req_cmp_i)));
  // R8
  retry_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && req_op_i == OP_RD_F2E |=> (rsp_status_o == ST_RETRY) == !rsp_tag_o);
  // R11
  bad_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && req_op_i > OP_LAST_LEGAL |=> rsp_status_o == ST_BAD_OP);
  // R9
  plain_tag_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && req_op_i <= OP_LAST_PLAIN |-> new_tag == old_tag);
endmodule

// File: tb/sim_amo_fe_unit.sv
module sim_amo_fe_unit;
  import amo_pkg::*;

  localparam int unsigned DEPTH = 16;
  localparam int unsigned TID_W = 8;
  localparam int unsigned AW    = $clog2(DEPTH);
  localparam logic [63:0] ONES  = '1;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              req_valid = 1'b0, req_ready, rsp_valid, rsp_ready = 1'b1;
  logic [4:0]        req_op = '0;
  logic [AW-1:0]     req_addr = '0;
  logic [63:0]       req_opnd = '0, req_cmp = '0, rsp_data;
  logic [TID_W-1:0]  req_tid = '0, rsp_tid;
  logic              rsp_tag;
  logic [1:0]        rsp_status;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [TID_W-1:0] tid_ctr = 8'd1;

  always #2 clk = ~clk;

  amo_fe_unit #(.DEPTH(DEPTH), .TID_W(TID_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_addr_i(req_addr), .req_opnd_i(req_opnd), .req_cmp_i(req_cmp),
    .req_tid_i(req_tid), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .rsp_data_o(rsp_data), .rsp_tag_o(rsp_tag), .rsp_status_o(rsp_status),
    .rsp_tid_o(rsp_tid)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [4:0] op, int addr, logic [63:0] opnd, logic [63:0] cmp);
    req_valid = 1'b1; req_op = op; req_addr = AW'(addr);
    req_opnd = opnd; req_cmp = cmp; req_tid = tid_ctr;
  endtask

  // one request, response sampled at the following falling edge
  task automatic op1(string req, logic [4:0] op, int addr, logic [63:0] opnd,
                     logic [63:0] cmp, logic [63:0] ed, logic et, logic [1:0] es);
    logic [TID_W-1:0] t;
    @(negedge clk);
    drive(op, addr, opnd, cmp);
    t = tid_ctr;
    @(negedge clk);
    req_valid = 1'b0;
    tid_ctr++;
    chk({req, " valid"}, 64'(rsp_valid), 64'd1);
    chk({req, " data"}, rsp_data, ed);
    chk({req, " tag"}, 64'(rsp_tag), 64'(et));
    chk({req, " status"}, 64'(rsp_status), 64'(es));
    chk("R2 tid", 64'(rsp_tid), 64'(t));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    op1("R1 read fresh", OP_RD_ANY, 3, 0, 0, 64'd0, 1'b0, ST_OK);
    op1("R1 read last", OP_RD_ANY, DEPTH-1, 0, 0, 64'd0, 1'b0, ST_OK);
  endtask

  task automatic t_arith;
    op1("R3 set", OP_WR_A2F, 1, 64'd10, 0, 64'd0, 1'b0, ST_OK);
    op1("R3 add", OP_ADD, 1, 64'd5, 0, 64'd10, 1'b1, ST_OK);
    op1("R3 sub", OP_SUB, 1, 64'd20, 0, 64'd15, 1'b1, ST_OK);
    op1("R3 sub wrap", OP_RD_ANY, 1, 0, 0, ONES - 64'd4, 1'b1, ST_OK);
    op1("R3 set ones", OP_WR_A2E, 2, ONES, 0, 64'd0, 1'b0, ST_OK);
    op1("R3 inc", OP_INC, 2, 64'd99, 0, ONES, 1'b0, ST_OK);
    op1("R3 R9 inc wrap empty kept", OP_RD_ANY, 2, 0, 0, 64'd0, 1'b0, ST_OK);
    op1("R3 dec", OP_DEC, 2, 64'd99, 0, 64'd0, 1'b0, ST_OK);
    op1("R3 dec wrap", OP_RD_ANY, 2, 0, 0, ONES, 1'b0, ST_OK);
  endtask

  task automatic t_minmax;
    op1("R4 set", OP_WR_A2F, 3, -64'sd5, 0, 64'd0, 1'b0, ST_OK);
    op1("R4 min keep", OP_MIN, 3, 64'd3, 0, -64'sd5, 1'b1, ST_OK);
    op1("R4 max", OP_MAX, 3, 64'd3, 0, -64'sd5, 1'b1, ST_OK);
    op1("R4 min neg", OP_MIN, 3, -64'sd7, 0, 64'd3, 1'b1, ST_OK);
    op1("R4 result", OP_RD_ANY, 3, 0, 0, -64'sd7, 1'b1, ST_OK);
  endtask

  task automatic t_logic;
    op1("R5 set", OP_WR_A2F, 4, 64'hF0F0, 0, 64'd0, 1'b0, ST_OK);
    op1("R5 and", OP_AND, 4, 64'h0FF0, 0, 64'hF0F0, 1'b1, ST_OK);
    op1("R5 or", OP_OR, 4, 64'h0F00, 0, 64'h00F0, 1'b1, ST_OK);
    op1("R5 xor", OP_XOR, 4, 64'h00FF, 0, 64'h0FF0, 1'b1, ST_OK);
    op1("R5 xchg", OP_XCHG, 4, 64'h1234, 0, 64'h0F0F, 1'b1, ST_OK);
    op1("R5 result", OP_RD_ANY, 4, 0, 0, 64'h1234, 1'b1, ST_OK);
  endtask

  task automatic t_cas;
    op1("R6 set", OP_WR_A2F, 7, 64'd50, 0, 64'd0, 1'b0, ST_OK);
    op1("R6 miss", OP_CAS, 7, 64'd60, 64'd51, 64'd50, 1'b1, ST_CAS_FAIL);
    op1("R6 hit", OP_CAS, 7, 64'd60, 64'd50, 64'd50, 1'b1, ST_OK);
    op1("R6 result", OP_RD_ANY, 7, 0, 0, 64'd60, 1'b1, ST_OK);
  endtask

  task automatic t_tags;
    op1("R8 read full on empty", OP_RD_F2E, 8, 0, 0, 64'd0, 1'b0, ST_RETRY);
    op1("R8 write full on empty", OP_WR_F2F, 8, 64'd9, 0, 64'd0, 1'b0, ST_RETRY);
    op1("R7 write empty", OP_WR_E2F, 8, 64'd11, 0, 64'd0, 1'b0, ST_OK);
    op1("R8 write empty on full", OP_WR_E2F, 8, 64'd12, 0, 64'd11, 1'b1, ST_RETRY);
    op1("R7 read keep full", OP_RD_F2F, 8, 0, 0, 64'd11, 1'b1, ST_OK);
    op1("R7 inc full", OP_INC_F2F, 8, 64'd77, 0, 64'd11, 1'b1, ST_OK);
    op1("R7 consume", OP_RD_F2E, 8, 0, 0, 64'd12, 1'b1, ST_OK);
    op1("R8 consume again", OP_RD_F2E, 8, 0, 0, 64'd12, 1'b0, ST_RETRY);
    op1("R8 inc on empty", OP_INC_F2F, 8, 0, 0, 64'd12, 1'b0, ST_RETRY);
    op1("R7 read empty", OP_RD_E2F, 8, 0, 0, 64'd12, 1'b0, ST_OK);
    op1("R8 read empty on full", OP_RD_E2F, 8, 0, 0, 64'd12, 1'b1, ST_RETRY);
    op1("R7 write any empty", OP_WR_A2E, 8, 64'd13, 0, 64'd12, 1'b1, ST_OK);
    op1("R7 read any", OP_RD_ANY, 8, 0, 0, 64'd13, 1'b0, ST_OK);
    op1("R7 read any tag kept", OP_RD_ANY, 8, 0, 0, 64'd13, 1'b0, ST_OK);
  endtask

  task automatic t_plain_tag;
    op1("R9 add on empty", OP_ADD, 10, 64'd3, 0, 64'd0, 1'b0, ST_OK);
    op1("R9 tag still empty", OP_RD_ANY, 10, 0, 0, 64'd3, 1'b0, ST_OK);
    op1("R9 fill", OP_WR_A2F, 10, 64'd4, 0, 64'd3, 1'b0, ST_OK);
    op1("R9 xor on full", OP_XOR, 10, 64'd1, 0, 64'd4, 1'b1, ST_OK);
    op1("R9 tag still full", OP_RD_ANY, 10, 0, 0, 64'd5, 1'b1, ST_OK);
  endtask

  task automatic t_bad_op;
    op1("R11 set", OP_WR_A2F, 9, 64'd44, 0, 64'd0, 1'b0, ST_OK);
    op1("R11 code 25", 5'd25, 9, 64'd1, 0, 64'd44, 1'b1, ST_BAD_OP);
    op1("R11 code 31", 5'd31, 9, 64'd1, 0, 64'd44, 1'b1, ST_BAD_OP);
    op1("R11 unchanged", OP_RD_ANY, 9, 0, 0, 64'd44, 1'b1, ST_OK);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      drive(OP_ADD, 5, 64'd1, 0);
      @(negedge clk);
      chk("R10 valid", 64'(rsp_valid), 64'd1);
      chk("R10 old value", rsp_data, 64'(i));
      chk("R10 tid", 64'(rsp_tid), 64'(tid_ctr));
      tid_ctr++;
    end
    req_valid = 1'b0;
    op1("R10 final", OP_RD_ANY, 5, 0, 0, 64'd3, 1'b0, ST_OK);
  endtask

  task automatic t_backpressure;
    logic [TID_W-1:0] t0;
    @(negedge clk);
    rsp_ready = 1'b0;
    drive(OP_WR_A2F, 6, 64'd77, 0);
    t0 = tid_ctr;
    @(negedge clk);
    tid_ctr++;
    drive(OP_RD_ANY, 6, 0, 0);
    chk("R12 first rsp", rsp_data, 64'd0);
    chk("R12 ready low", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk("R12 held valid", 64'(rsp_valid), 64'd1);
    chk("R12 held tid", 64'(rsp_tid), 64'(t0));
    chk("R12 held data", rsp_data, 64'd0);
    chk("R12 still blocked", 64'(req_ready), 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 second tid", 64'(rsp_tid), 64'(tid_ctr));
    chk("R12 second data", rsp_data, 64'd77);
    chk("R12 second tag", 64'(rsp_tag), 64'd1);
    tid_ctr++;
    @(negedge clk);
    chk("R12 drained", 64'(rsp_valid), 64'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog R2: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_arith();
    t_minmax();
    t_logic();
    t_cas();
    t_tags();
    t_plain_tag();
    t_bad_op();
    t_back_to_back();
    t_backpressure();
    finish_run();
  end
endmodule